// File: doc/BRIEF.md
# Port Edge Interrupt Controller

This block watches up to 32 general-purpose port pins and turns their transitions into one level-sensitive interrupt request for a parent interrupt controller. Each pin first passes through a two-flop synchronizer. A per-pin edge detector then reports either falling transitions only or any transition, as selected in software. A detected transition latches a sticky bit in an event register. A mask register decides which of the latched bits may raise the shared interrupt line.

Software uses a small synchronous register bus with one request strobe, a write enable, a byte address and 32-bit data. There are three words: the event word, the enable word and the edge-select word. Source vector n always maps to data bit 31−n, so vector 0 is the leftmost bit. After it handles a source, the service routine writes a word with only that source's bit set to the event word. This acknowledges the source and clears the bit.

Top module: `port_edge_intc`

## Requirements
- R1: Register decode uses byte addresses: 0x0C is the event word, 0x10 is the enable word and 0x14 is the edge-select word. Enable and edge-select words read back what was written. Read data appears on `bus_rdata_o` one clock after the read request is accepted.
- R2: Pin input `pin_i[n]` is source vector n, and it occupies bit 31−n of every register word.
- R3: An edge-select bit of 1 makes its pin report falling transitions only. A bit of 0 makes it report both rising and falling transitions.
- R4: A detected transition sets its event bit whether or not the source is enabled.
- R5: Writing the event word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: If a transition is detected in the same cycle that the event word write clears its bit, the bit stays set.
- R7: `irq_o` is a registered output. It goes high one clock after any bit is set in both the event word and the enable word, and low one clock after no such bit remains. An enable bit of 0 blocks its source.
- R8: A pin change is first seen in the event word at the third rising clock edge after the change. A read accepted at that edge still returns the old value.
- R9: Synchronous active-high reset clears all three words, the read data and `irq_o`. After reset every source is masked and detects both edges.
- R10: A read at any address other than the three mapped ones returns zero. A write there changes no register.
- R11: An event bit is never set by a bus write. It can only be set by a detected transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Asynchronous port pin levels; bit n is source vector n |
| bus_req_i | input | 1 | Register access request, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | AW | Byte address of the register |
| bus_wdata_i | input | DW | Write data, bit 31 most significant |
| bus_rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Merged level interrupt toward the parent controller |

## Verification
Two functions can act on the same event bit in one cycle: a bus write that clears the bit, and a new transition arriving from the synchronizer. The bench first latches an event on one pin. It then toggles that pin again and times the acknowledge write so the write is captured on the exact edge where the second transition reaches the event word. Reading the word back must still show the bit set. A second acknowledge with the pin quiet must clear it. The same counted timing proves that a read accepted on the edge where the transition lands still returns the old value.

// File: rtl/pei_pkg.sv
package pei_pkg;
  localparam int OFF_EVENT = 'h0C;
  localparam int OFF_ENABLE = 'h10;
  localparam int OFF_EDGESEL = 'h14;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EVENT,
    SEL_ENABLE,
    SEL_EDGESEL
  } reg_sel_e;
endpackage

// File: rtl/pei_pin_sync.sv
module pei_pin_sync #(
  parameter int NPINS = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] fall_only_i,
  output logic [NPINS-1:0] hit_o
);
  localparam int TOP = STAGES - 1;

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], pin_i[n]};
        prev_q  <= chain_q[TOP];
      end
    end

    always_comb begin
      if (fall_only_i[n]) hit_o[n] = prev_q & ~chain_q[TOP];
      else                hit_o[n] = prev_q ^ chain_q[TOP];
    end
  end
endmodule

// File: rtl/pei_regfile.sv
module pei_regfile
  import pei_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NPINS-1:0] hit_i,
  output logic [DW-1:0]    rdata_o,
  output logic [NPINS-1:0] ev_o,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] fall_only_o
);
  localparam int SPARE = DW - NPINS;

  logic [NPINS-1:0] ev_q, en_q, fsel_q;
  logic [NPINS-1:0] wr_lane;
  logic [DW-1:0]    ev_word, en_word, fsel_word;
  logic [DW-1:0]    rdata_q;
  reg_sel_e         sel;

  // lane n <-> word bit DW-1-n
  for (genvar n = 0; n < NPINS; n++) begin : g_map
    assign wr_lane[n]           = wdata_i[DW-1-n];
    assign ev_word[DW-1-n]      = ev_q[n];
    assign en_word[DW-1-n]      = en_q[n];
    assign fsel_word[DW-1-n]    = fsel_q[n];
  end
  if (SPARE > 0) begin : g_spare
    assign ev_word[SPARE-1:0]   = '0;
    assign en_word[SPARE-1:0]   = '0;
    assign fsel_word[SPARE-1:0] = '0;
  end

  always_comb begin
    if (addr_i == AW'(OFF_EVENT))        sel = SEL_EVENT;
    else if (addr_i == AW'(OFF_ENABLE))  sel = SEL_ENABLE;
    else if (addr_i == AW'(OFF_EDGESEL)) sel = SEL_EDGESEL;
    else                                 sel = SEL_NONE;
  end

  logic do_wr, do_rd;
  logic [NPINS-1:0] ack_lane;
  assign do_wr    = req_i & we_i;
  assign do_rd    = req_i & ~we_i;
  assign ack_lane = (do_wr && sel == SEL_EVENT) ? wr_lane : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ev_q   <= '0;
      en_q   <= '0;
      fsel_q <= '0;
    end else begin
      ev_q <= (ev_q & ~ack_lane) | hit_i;
      if (do_wr && sel == SEL_ENABLE)  en_q   <= wr_lane;
      if (do_wr && sel == SEL_EDGESEL) fsel_q <= wr_lane;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
    end else if (do_rd) begin
      case (sel)
        SEL_EVENT:   rdata_q <= ev_word;
        SEL_ENABLE:  rdata_q <= en_word;
        SEL_EDGESEL: rdata_q <= fsel_word;
        default:     rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o     = rdata_q;
  assign ev_o        = ev_q;
  assign en_o        = en_q;
  assign fall_only_o = fsel_q;
endmodule

// File: rtl/pei_irq_merge.sv
module pei_irq_merge #(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NPINS-1:0] ev_i,
  input  logic [NPINS-1:0] en_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_q <= 1'b0;
    else       irq_q <= |(ev_i & en_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/port_edge_intc.sv
module port_edge_intc #(
  parameter int NPINS = 32,
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NPINS-1:0] pin_i,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             irq_o
);
  logic [NPINS-1:0] edge_hit;
  logic [NPINS-1:0] ev_lane, en_lane, fsel_lane;

  pei_pin_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .pin_i       (pin_i),
    .fall_only_i (fsel_lane),
    .hit_o       (edge_hit)
  );

  pei_regfile #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_i       (bus_req_i),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .hit_i       (edge_hit),
    .rdata_o     (bus_rdata_o),
    .ev_o        (ev_lane),
    .en_o        (en_lane),
    .fall_only_o (fsel_lane)
  );

  pei_irq_merge #(.NPINS(NPINS)) u_irq (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .ev_i  (ev_lane),
    .en_i  (en_lane),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/pei_chk.sv
module pei_chk
  import pei_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             req_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_i,
  input logic [NPINS-1:0] hit_i,
  input logic [NPINS-1:0] ev_i,
  input logic [NPINS-1:0] en_i,
  input logic [NPINS-1:0] fsel_i,
  input logic             irq_i
);
  function automatic logic [NPINS-1:0] to_lane(input logic [DW-1:0] w);
    logic [NPINS-1:0] r;
    for (int n = 0; n < NPINS; n++) r[n] = w[DW-1-n];
    return r;
  endfunction

  logic mapped, wr_ev, wr_en;
  assign mapped = (addr_i == AW'(OFF_EVENT)) || (addr_i == AW'(OFF_ENABLE)) ||
                  (addr_i == AW'(OFF_EDGESEL));
  assign wr_ev  = req_i && we_i && (addr_i == AW'(OFF_EVENT));
  assign wr_en  = req_i && we_i && (addr_i == AW'(OFF_ENABLE));

  // R9
  reset_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (ev_i == '0 && en_i == '0 && fsel_i == '0 && !irq_i && rdata_i == '0));

  // R7
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_i == (|($past(ev_i) & $past(en_i))));

  // R4
  edge_sets_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|hit_i) |=> ((ev_i & $past(hit_i)) == $past(hit_i)));

  // R5
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_ev |=> ((ev_i & $past(to_lane(wdata_i) & ~hit_i)) == '0));

  // R11
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ev_i & ~$past(ev_i) & ~$past(hit_i)) == '0);

  // R1
  enable_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_en |=> (en_i == $past(to_lane(wdata_i))));

  // R10
  unmapped_write_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && we_i && !mapped) |=> ($stable(en_i) && $stable(fsel_i) &&
                                    ((ev_i & $past(ev_i)) == $past(ev_i))));

  // R10
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && !we_i && !mapped) |=> (rdata_i == '0));
endmodule

bind port_edge_intc pei_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .req_i   (bus_req_i),
  .we_i    (bus_we_i),
  .addr_i  (bus_addr_i),
  .wdata_i (bus_wdata_i),
  .rdata_i (bus_rdata_o),
  .hit_i   (edge_hit),
  .ev_i    (ev_lane),
  .en_i    (en_lane),
  .fsel_i  (fsel_lane),
  .irq_i   (irq_o)
);

// File: tb/port_edge_intc_tb_top.sv
module port_edge_intc_tb_top;
  localparam logic [7:0] A_EV = 8'h0C, A_EN = 8'h10, A_ES = 8'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  port_edge_intc dut_i (
    .clk_i(clk), .rst_i(rst), .pin_i(pins), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] start;
    logic [31:0] fin;
    logic [31:0] esel;
    logic [31:0] en;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 32'h8000_0000},
    '{32'h0000_0001, 32'h0000_0000, 32'h8000_0000, 32'h0000_0000},
    '{32'h0000_0000, 32'h0000_0003, 32'hC000_0000, 32'hFFFF_FFFF},
    '{32'hFFFF_0000, 32'h0000_FFFF, 32'hAAAA_AAAA, 32'h0000_0001},
    '{32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001},
    '{32'h1234_5678, 32'h8765_4321, 32'h0F0F_0F0F, 32'hFFFF_0000}
  };

  function automatic logic [31:0] exp_event(input logic [31:0] a, b, es);
    logic [31:0] r;
    for (int n = 0; n < 32; n++) begin
      logic rise, fall;
      rise = !a[n] && b[n];
      fall = a[n] && !b[n];
      r[31-n] = es[31-n] ? fall : (rise || fall);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic drive_pins(input logic [31:0] v);
    @(negedge clk);
    pins = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk("R9 irq after reset", {31'b0, irq}, 32'h0);
    rd(A_EV, d); chk("R9 event reset", d, 32'h0);
    rd(A_EN, d); chk("R9 enable reset", d, 32'h0);
    rd(A_ES, d); chk("R9 edge-select reset", d, 32'h0);

    // R1 readback
    wr(A_EN, 32'h1234_5678); rd(A_EN, d); chk("R1 enable readback", d, 32'h1234_5678);
    wr(A_ES, 32'h9ABC_DEF0); rd(A_ES, d); chk("R1 edge-select readback", d, 32'h9ABC_DEF0);

    // R10 unmapped access
    rd(8'h00, d); chk("R10 read 0x00", d, 32'h0);
    rd(8'h18, d); chk("R10 read 0x18", d, 32'h0);
    rd(8'h0D, d); chk("R10 read 0x0D", d, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h11, 32'h0);
    rd(A_EN, d); chk("R10 enable untouched", d, 32'h1234_5678);
    rd(A_ES, d); chk("R10 edge-select untouched", d, 32'h9ABC_DEF0);

    // table walk: R2 R3 R4 R7
    for (int i = 0; i < NV; i++) begin
      wr(A_EN, 32'h0);
      wr(A_ES, VECS[i].esel);
      drive_pins(VECS[i].start);
      wr(A_EV, 32'hFFFF_FFFF);
      drive_pins(VECS[i].fin);
      e = exp_event(VECS[i].start, VECS[i].fin, VECS[i].esel);
      rd(A_EV, d); chk($sformatf("R2/R3/R4 vector %0d event", i), d, e);
      chk($sformatf("R7 vector %0d masked irq", i), {31'b0, irq}, 32'h0);
      wr(A_EN, VECS[i].en);
      @(negedge clk);
      chk($sformatf("R7 vector %0d irq", i), {31'b0, irq}, {31'b0, |(e & VECS[i].en)});
    end

    // R5 / R11 acknowledge semantics
    wr(A_EN, 32'h0); wr(A_ES, 32'h0);
    drive_pins(32'h0); wr(A_EV, 32'hFFFF_FFFF);
    drive_pins(32'h0000_0003);
    wr(A_EV, 32'h4000_0000); rd(A_EV, d); chk("R5 clear only written bit", d, 32'h8000_0000);
    wr(A_EV, 32'h0); rd(A_EV, d); chk("R5/R11 zero write keeps bits", d, 32'h8000_0000);
    wr(A_EV, 32'h8000_0000); rd(A_EV, d); chk("R5 last bit cleared", d, 32'h0);

    // R8 latency and R7 timing
    wr(A_EN, 32'h2000_0000);
    @(negedge clk); pins = 32'h0000_0007;      // N0: vector 2 rises
    @(negedge clk);                             // N1
    rd(A_EV, d);                                // captured at third edge
    chk("R8 old value at third edge", d, 32'h0);
    chk("R7 irq not yet", {31'b0, irq}, 32'h0);
    rd(A_EV, d); chk("R8 event visible", d, 32'h2000_0000);
    chk("R7 irq raised", {31'b0, irq}, 32'h1);

    // R6 clear and new edge in the same cycle
    @(negedge clk); pins = 32'h0000_0003;      // N0: vector 2 falls
    @(negedge clk);                             // N1
    @(negedge clk);                             // N2
    req = 1'b1; we = 1'b1; addr = A_EV; wdata = 32'h2000_0000;
    @(negedge clk); req = 1'b0; we = 1'b0;
    rd(A_EV, d); chk("R6 edge wins over clear", d, 32'h2000_0000);
    wr(A_EV, 32'h2000_0000); rd(A_EV, d); chk("R6 quiet clear", d, 32'h0);
    @(negedge clk);
    chk("R7 irq drops", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule